// File: doc/BRIEF.md
# Synthesizer Divider Chain

This block contains the digital dividers of an integer-N frequency synthesizer. Two dividers run in two clock domains. The reference divider takes the crystal reference clock down to the phase-detector comparison rate. The main divider counts output cycles of a 32/33 dual-modulus prescaler. It drives the prescaler's modulus line from a swallow count, so that one main period spans a programmed number of VCO-side counts.

The effective main ratio is the 12-bit channel word, clamped to the legal window. It may be raised by two counts, which moves the local oscillator by one comparison step. Whether the step applies in receive or in transmit is chosen by a configuration bit. A new word, offset or reference choice is loaded only when the divider concerned wraps, so a period already under way always completes with its old ratio.

The phase detector, charge pump, VCO and prescaler core sit outside this block. The channel word, the offset bit and the mode are expected to be stable with respect to the prescaler clock, and the reference-select bit with respect to the reference clock.

Top module: `synthDividerChain`

## Requirements
- R1: The reference divider issues one `refPulse` every 6 `refClk` cycles when `refSel` is 0, and every 12 when `refSel` is 1.
- R2: A change of `refSel` takes effect only after the next `refPulse`; the period in progress keeps its old length.
- R3: One main period lasts M = N div 32 `preClk` cycles and ends with `mainPulse`. Summing 33 for each cycle with `modCtl` high and 32 for each cycle with it low gives exactly the effective ratio N.
- R4: `modCtl` is high during the first A = N mod 32 cycles of each main period and low for the rest of it; it is low in the `mainPulse` cycle.
- R5: N is the channel word plus 2 when `rxMode` XOR `loShift` is 1 (`rxMode` = 1 is receive). Otherwise N is the channel word.
- R6: A channel word below 1024 is treated as 1024 and one above 4093 as 4093. The clamp is applied before the offset.
- R7: A change of `chanWord`, `rxMode` or `loShift` takes effect only at the next main terminal count.
- R8: `refPulse` and `mainPulse` are each high for a single cycle of their own clock.
- R9: While a reset is high, its divider holds its count at zero and produces no pulse. The first main period after `mainRst` falls is a full period of the ratio present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock (6.144 or 12.288 MHz) |
| refRst | input | 1 | Synchronous reset, reference domain |
| refSel | input | 1 | Reference ratio select: 0 divides by 6, 1 by 12 |
| preClk | input | 1 | Prescaler output clock |
| mainRst | input | 1 | Synchronous reset, prescaler domain |
| chanWord | input | 12 | Programmed channel word, LO = word x 0.512 MHz |
| loShift | input | 1 | Offset direction: 0 offsets receive, 1 offsets transmit |
| rxMode | input | 1 | 1 receive, 0 transmit |
| refPulse | output | 1 | Divided reference pulse |
| mainPulse | output | 1 | Divided main pulse |
| modCtl | output | 1 | Prescaler modulus select: 1 selects 33, 0 selects 32 |

## Verification
Some properties are checked on every cycle. Each pulse lasts one cycle. The reference and main pulse spacings stay inside the legal window. `modCtl` is low at a terminal count and can only rise in the cycle right after one. The exact ratio of every period is shown only by the bench scenarios. These cover clamping and offset arithmetic, the mode/offset-bit combinations, and the deferral of a ratio or reference change to the next wrap. The bench's cycle model checks them against the modulus pattern it expects.

// File: rtl/synthDivPkg.sv
`timescale 1ns/1ps
package synthDivPkg;
  // Strobes from the control to the counters and the outputs
  typedef struct packed {
    logic refWrap;    // reference terminal count
    logic mainWrap;   // main terminal count
    logic swallowOn;  // prescaler at the high modulus
  } divStrobes_t;
endpackage

// File: rtl/divCounter.sv
`timescale 1ns/1ps
module divCounter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  output logic [WIDTH-1:0] count
);
  always_ff @(posedge clk) begin
    if (clear) count <= '0;
    else       count <= count + WIDTH'(1);
  end
endmodule

// File: rtl/divDatapath.sv
`timescale 1ns/1ps
module divDatapath
  import synthDivPkg::*;
#(
  parameter int REF_W = 4,
  parameter int MOD_W = 7
) (
  input  logic             refClk,
  input  logic             refRst,
  input  logic             preClk,
  input  logic             mainRst,
  input  divStrobes_t      strobes,
  output logic [REF_W-1:0] refCount,
  output logic [MOD_W-1:0] mainCount
);
  logic refClear;
  logic mainClear;

  assign refClear  = refRst  | strobes.refWrap;
  assign mainClear = mainRst | strobes.mainWrap;

  divCounter #(.WIDTH(REF_W)) uRefCnt (
    .clk(refClk), .clear(refClear), .count(refCount)
  );

  divCounter #(.WIDTH(MOD_W)) uMainCnt (
    .clk(preClk), .clear(mainClear), .count(mainCount)
  );
endmodule

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
module divCtrl
  import synthDivPkg::*;
#(
  parameter int CHAN_W       = 12,
  parameter int PRE_SHIFT    = 5,
  parameter int MIN_WORD     = 1024,
  parameter int MAX_WORD     = 4093,
  parameter int OFFSET_STEPS = 2,
  parameter int REF_DIV_LO   = 6,
  parameter int REF_DIV_HI   = 12,
  parameter int RATIO_W      = 12,
  parameter int MOD_W        = 7,
  parameter int REF_W        = 4
) (
  input  logic              refClk,
  input  logic              refRst,
  input  logic              refSel,
  input  logic              preClk,
  input  logic              mainRst,
  input  logic [CHAN_W-1:0] chanWord,
  input  logic              loShift,
  input  logic              rxMode,
  input  logic [REF_W-1:0]  refCount,
  input  logic [MOD_W-1:0]  mainCount,
  output divStrobes_t       strobes
);
  localparam logic [CHAN_W-1:0]  LOW_LIMIT  = CHAN_W'(MIN_WORD);
  localparam logic [CHAN_W-1:0]  HIGH_LIMIT = CHAN_W'(MAX_WORD);
  localparam logic [RATIO_W-1:0] STEP       = RATIO_W'(OFFSET_STEPS);
  localparam logic [REF_W-1:0]   DIV_LO     = REF_W'(REF_DIV_LO);
  localparam logic [REF_W-1:0]   DIV_HI     = REF_W'(REF_DIV_HI);

  logic [CHAN_W-1:0]    clampedWord;
  logic [RATIO_W-1:0]   nextRatio;
  logic [MOD_W-1:0]     nextMod;
  logic [PRE_SHIFT-1:0] nextSwallow;
  logic [MOD_W-1:0]     modLatched;
  logic [PRE_SHIFT-1:0] swallowLatched;
  logic [REF_W-1:0]     refDivLatched;
  logic                 offsetOn;

  // Clamp, then apply the one-step LO offset for the active direction (R5, R6)
  always_comb begin
    if (chanWord < LOW_LIMIT)       clampedWord = LOW_LIMIT;
    else if (chanWord > HIGH_LIMIT) clampedWord = HIGH_LIMIT;
    else                            clampedWord = chanWord;
  end

  assign offsetOn    = rxMode ^ loShift;
  assign nextRatio   = RATIO_W'(clampedWord) + (offsetOn ? STEP : '0);
  assign nextMod     = nextRatio[RATIO_W-1:PRE_SHIFT];
  assign nextSwallow = nextRatio[PRE_SHIFT-1:0];

  // Ratio is reloaded only at reset or terminal count (R7)
  always_ff @(posedge preClk) begin
    if (mainRst || strobes.mainWrap) begin
      modLatched     <= nextMod;
      swallowLatched <= nextSwallow;
    end
  end

  // Reference ratio is reloaded only at reset or terminal count (R2)
  always_ff @(posedge refClk) begin
    if (refRst || strobes.refWrap)
      refDivLatched <= refSel ? DIV_HI : DIV_LO;
  end

  always_comb begin
    strobes.mainWrap  = (mainCount == modLatched - MOD_W'(1));
    strobes.swallowOn = (mainCount < MOD_W'(swallowLatched));
    strobes.refWrap   = (refCount == refDivLatched - REF_W'(1));
  end
endmodule

// File: rtl/synthDividerChain.sv
`timescale 1ns/1ps
module synthDividerChain
  import synthDivPkg::*;
#(
  parameter int CHAN_W       = 12,
  parameter int PRE_LOW      = 32,
  parameter int MIN_WORD     = 1024,
  parameter int MAX_WORD     = 4093,
  parameter int OFFSET_STEPS = 2,
  parameter int REF_DIV_LO   = 6,
  parameter int REF_DIV_HI   = 12
) (
  input  logic              refClk,
  input  logic              refRst,
  input  logic              refSel,
  input  logic              preClk,
  input  logic              mainRst,
  input  logic [CHAN_W-1:0] chanWord,
  input  logic              loShift,
  input  logic              rxMode,
  output logic              refPulse,
  output logic              mainPulse,
  output logic              modCtl
);
  localparam int PRE_SHIFT = $clog2(PRE_LOW);
  localparam int RATIO_W   = $clog2(MAX_WORD + OFFSET_STEPS + 1);
  localparam int MOD_W     = RATIO_W - PRE_SHIFT;
  localparam int REF_W     = $clog2(REF_DIV_HI + 1);

  divStrobes_t      strobes;
  logic [REF_W-1:0] refCount;
  logic [MOD_W-1:0] mainCount;

  divCtrl #(
    .CHAN_W(CHAN_W), .PRE_SHIFT(PRE_SHIFT), .MIN_WORD(MIN_WORD),
    .MAX_WORD(MAX_WORD), .OFFSET_STEPS(OFFSET_STEPS),
    .REF_DIV_LO(REF_DIV_LO), .REF_DIV_HI(REF_DIV_HI),
    .RATIO_W(RATIO_W), .MOD_W(MOD_W), .REF_W(REF_W)
  ) uCtrl (
    .refClk(refClk), .refRst(refRst), .refSel(refSel),
    .preClk(preClk), .mainRst(mainRst), .chanWord(chanWord),
    .loShift(loShift), .rxMode(rxMode), .refCount(refCount),
    .mainCount(mainCount), .strobes(strobes)
  );

  divDatapath #(.REF_W(REF_W), .MOD_W(MOD_W)) uPath (
    .refClk(refClk), .refRst(refRst), .preClk(preClk),
    .mainRst(mainRst), .strobes(strobes),
    .refCount(refCount), .mainCount(mainCount)
  );

  assign refPulse  = strobes.refWrap;
  assign mainPulse = strobes.mainWrap;
  assign modCtl    = strobes.swallowOn;
endmodule

// File: rtl/divChecker.sv
`timescale 1ns/1ps
module divChecker #(
  parameter int PRE_LOW      = 32,
  parameter int MIN_WORD     = 1024,
  parameter int MAX_WORD     = 4093,
  parameter int OFFSET_STEPS = 2,
  parameter int REF_DIV_LO   = 6,
  parameter int REF_DIV_HI   = 12
) (
  input logic refClk,
  input logic refRst,
  input logic preClk,
  input logic mainRst,
  input logic refPulse,
  input logic mainPulse,
  input logic modCtl
);
  localparam int MIN_MOD = MIN_WORD / PRE_LOW;
  localparam int MAX_MOD = (MAX_WORD + OFFSET_STEPS) / PRE_LOW;

  int refGap;
  int mainGap;

  always_ff @(posedge refClk) begin
    if (refRst || refPulse) refGap <= 0;
    else                    refGap <= refGap + 1;
  end

  always_ff @(posedge preClk) begin
    if (mainRst || mainPulse) mainGap <= 0;
    else                      mainGap <= mainGap + 1;
  end

  p_ref_single_r8: assert property (@(posedge refClk) disable iff (refRst)
    refPulse |=> !refPulse);
  p_main_single_r8: assert property (@(posedge preClk) disable iff (mainRst)
    mainPulse |=> !mainPulse);
  p_ref_gap_min_r1: assert property (@(posedge refClk) disable iff (refRst)
    refPulse |-> refGap >= REF_DIV_LO - 1);
  p_ref_gap_max_r1: assert property (@(posedge refClk) disable iff (refRst)
    refGap <= REF_DIV_HI - 1);
  p_main_gap_min_r3: assert property (@(posedge preClk) disable iff (mainRst)
    mainPulse |-> mainGap >= MIN_MOD - 1);
  p_main_gap_max_r3: assert property (@(posedge preClk) disable iff (mainRst)
    mainGap <= MAX_MOD - 1);
  p_mod_low_at_wrap_r4: assert property (@(posedge preClk) disable iff (mainRst)
    mainPulse |-> !modCtl);
  p_mod_rise_after_wrap_r4: assert property (@(posedge preClk) disable iff (mainRst)
    $rose(modCtl) |-> $past(mainPulse));
endmodule

bind synthDividerChain divChecker uChk (
  .refClk(refClk), .refRst(refRst), .preClk(preClk), .mainRst(mainRst),
  .refPulse(refPulse), .mainPulse(mainPulse), .modCtl(modCtl)
);

// File: tb/tb_synthDividerChain.sv
`timescale 1ns/1ps
module tb_synthDividerChain;
  logic        refClk = 1'b0;
  logic        preClk = 1'b0;
  logic        refRst = 1'b1;
  logic        mainRst = 1'b1;
  logic        refSel = 1'b0;
  logic [11:0] chanWord = 12'd1500;
  logic        loShift = 1'b0;
  logic        rxMode = 1'b0;
  logic        refPulse, mainPulse, modCtl;

  int checks = 0;
  int errors = 0;

  synthDividerChain dut (
    .refClk(refClk), .refRst(refRst), .refSel(refSel), .preClk(preClk),
    .mainRst(mainRst), .chanWord(chanWord), .loShift(loShift),
    .rxMode(rxMode), .refPulse(refPulse), .mainPulse(mainPulse),
    .modCtl(modCtl)
  );

  initial forever #2.5 preClk = ~preClk;   // 200 MHz
  initial forever #6   refClk = ~refClk;

  function automatic void check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  // Reference model: expected per-cycle output patterns held in queues
  function automatic int effRatio(int w, bit rx, bit ls);
    int c;
    c = (w < 1024) ? 1024 : ((w > 4093) ? 4093 : w);
    return c + ((rx ^ ls) ? 2 : 0);
  endfunction

  bit modQ[$];
  bit pulQ[$];
  bit refQ[$];

  function automatic void fillMain();
    int n, m, a;
    n = effRatio(int'(chanWord), rxMode, loShift);
    m = n / 32;
    a = n % 32;
    for (int i = 0; i < m; i++) begin
      modQ.push_back(i < a);
      pulQ.push_back(i == m - 1);
    end
  endfunction

  function automatic void fillRef();
    int d;
    d = refSel ? 12 : 6;
    for (int i = 0; i < d; i++) refQ.push_back(i == d - 1);
  endfunction

  always @(posedge preClk) begin
    if (mainRst) begin
      modQ.delete(); pulQ.delete(); fillMain();
    end else begin
      void'(modQ.pop_front()); void'(pulQ.pop_front());
      if (modQ.size() == 0) fillMain();
    end
  end

  always @(posedge refClk) begin
    if (refRst) begin
      refQ.delete(); fillRef();
    end else begin
      void'(refQ.pop_front());
      if (refQ.size() == 0) fillRef();
    end
  end

  always @(negedge preClk) begin
    if (!mainRst && modQ.size() > 0) begin
      check("R4 modCtl per cycle", int'(modCtl), int'(modQ[0]));
      check("R8 mainPulse per cycle", int'(mainPulse), int'(pulQ[0]));
    end
  end

  always @(negedge refClk) begin
    if (!refRst && refQ.size() > 0)
      check("R1 refPulse per cycle", int'(refPulse), int'(refQ[0]));
  end

  // Sync to a main pulse, then measure the following full period
  task automatic measureMain(output int sum, output int highs);
    do @(negedge preClk); while (mainPulse !== 1'b1);
    sum = 0; highs = 0;
    do begin
      @(negedge preClk);
      sum += modCtl ? 33 : 32;
      highs += int'(modCtl);
    end while (mainPulse !== 1'b1);
  endtask

  task automatic measureRef(output int gap);
    do @(negedge refClk); while (refPulse !== 1'b1);
    gap = 0;
    do begin @(negedge refClk); gap++; end while (refPulse !== 1'b1);
  endtask

  task automatic setMain(int w, bit rx, bit ls);
    @(posedge preClk); #1;
    chanWord = 12'(w); rxMode = rx; loShift = ls;
  endtask

  task automatic runRatio(string tag, int w, bit rx, bit ls, int exp);
    int s, h;
    setMain(w, rx, ls);
    measureMain(s, h);
    check(tag, s, exp);
  endtask

  initial begin
    int s, h, g;
    // R9: no pulses while reset is held
    repeat (4) @(negedge preClk);
    check("R9 mainPulse in reset", int'(mainPulse), 0);
    check("R9 refPulse in reset", int'(refPulse), 0);
    @(posedge refClk); #1 refRst = 1'b0;
    @(posedge preClk); #1 mainRst = 1'b0;
    // R9: the first period after reset is complete
    s = 0;
    do begin @(negedge preClk); s += modCtl ? 33 : 32; end while (mainPulse !== 1'b1);
    check("R9 first period ratio", s, 1500);
    @(negedge preClk);
    check("R8 pulse dropped after one cycle", int'(mainPulse), 0);

    // R3 / R4: steady ratio and swallow count
    measureMain(s, h);
    check("R3 ratio 1500", s, 1500);
    check("R4 swallow cycles for 1500", h, 28);
    runRatio("R3 ratio 2611", 2611, 1'b0, 1'b0, 2611);
    setMain(1024, 1'b0, 1'b0);
    measureMain(s, h);
    check("R4 no swallow at 1024", h, 0);
    check("R3 ratio 1024", s, 1024);

    // R5: offset direction
    runRatio("R5 rx ls0 offset", 1500, 1'b1, 1'b0, 1502);
    runRatio("R5 tx ls0 no offset", 1500, 1'b0, 1'b0, 1500);
    runRatio("R5 tx ls1 offset", 1500, 1'b0, 1'b1, 1502);
    runRatio("R5 rx ls1 no offset", 1500, 1'b1, 1'b1, 1500);

    // R6: clamping, before the offset
    runRatio("R6 low clamp 500", 500, 1'b0, 1'b0, 1024);
    runRatio("R6 low clamp 1023", 1023, 1'b0, 1'b0, 1024);
    runRatio("R6 top edge 4093", 4093, 1'b0, 1'b0, 4093);
    runRatio("R6 high clamp 4095", 4095, 1'b0, 1'b0, 4093);
    runRatio("R6 clamp then offset", 4095, 1'b1, 1'b0, 4095);

    // R7: a mid-period change waits for the terminal count
    setMain(1500, 1'b0, 1'b0);
    measureMain(s, h);
    s = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge preClk);
      s += modCtl ? 33 : 32;
      if (mainPulse === 1'b1) break;
      if (k == 3) begin @(posedge preClk); #1 chanWord = 12'd2600; rxMode = 1'b1; end
    end
    check("R7 period keeps old ratio", s, 1500);
    measureMain(s, h);
    check("R7 new ratio after wrap", s, 2602);

    // R1 / R2: reference ratios and deferred select change
    measureRef(g);
    check("R1 divide by 6", g, 6);
    @(posedge refClk); #1 refSel = 1'b1;
    g = 0;
    do begin @(negedge refClk); g++; end while (refPulse !== 1'b1);
    check("R2 select change deferred", g, 6);
    measureRef(g);
    check("R1 divide by 12", g, 12);
    @(posedge refClk); #1 refSel = 1'b0;
    measureRef(g);
    check("R1 back to 6", g, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule